// File: doc/BRIEF.md
# PLL Divider Solver with Frequency-Range Lookup

This block works out the divider settings for a serial-link PHY PLL. It takes a reference frequency and a wanted lane bit-clock frequency, both whole numbers of MHz. After a start pulse it derives the permitted span of input dividers. It then walks that span one candidate per clock and keeps the divider whose product with the target leaves the smallest remainder against the reference. From the winner it derives the feedback divider and the frequency actually reached.

In the same run it looks the target up in a fixed table of 39 ascending thresholds to pick a frequency-range code. It also produces the five configuration bytes that a serial test-port writer sends to the PHY: VCO range, frequency range, input divider, feedback low part and feedback high part. A one-cycle `done` pulse marks the end of a run. `ok` tells whether the run was error free, and the results stay on the outputs until the next accepted start.

Top module: `pll_solver`

## Requirements
- R1: While reset is held low and after it is released, `busy`, `done`, `ok`, `prediv`, `fbdiv` and `range_code` are zero.
- R2: With upper bound `ref_mhz/5` and lower bound `ref_mhz/40+1` (or 1 when `ref_mhz/40` is zero), an upper bound below the lower bound raises `err_bounds` with `done`. In that case `prediv` is 1, and `fbdiv` and `achieved_mhz` are 0.
- R3: Candidates run from the lower bound up to one below the upper bound, in rising order. A candidate i wins only if `(tgt*i) mod ref` is strictly below the best remainder so far and `tgt*i/ref` is below 512, so the earliest candidate wins a tie. The best remainder starts at `ref` and the divider defaults to 1 when nothing wins.
- R4: `fbdiv = tgt*prediv/ref` and `achieved_mhz = ref*fbdiv/prediv`, both with integer division.
- R5: `range_code` is the code of the first table entry whose threshold is at or above the target, and `cfg_range` is that code shifted left by one bit. Thresholds in MHz, ascending: 90,100,110,130,140,150,170,180,200,220,240,250,270,300,330,360,400,450,500,550,600,650,700,750,800,850,900,950,1000,1050,1100,1150,1200,1250,1300,1350,1400,1450,1500. Matching codes in hex: 01 10 20 01 11 21 02 12 22 03 13 23 04 14 05 15 25 06 16 07 17 08 18 09 19 29 39 0a 1a 2a 3a 0b 1b 2b 3b 0c 1c 2c 3c.
- R6: A target above 1500 raises `err_range` with `done`, and `range_code` and `cfg_range` are then 0.
- R7: `cfg_indiv` is `prediv-1` in 8 bits. With m = `fbdiv-1` taken modulo 2^32, `cfg_fb_lo` is m[4:0] and `cfg_fb_hi` is the low 8 bits of `(m>>5) | 0x80`.
- R8: `cfg_vco` is the low 8 bits of `0x80 | ((tgt/200)<<3) | 0x03`.
- R9: `done` lasts exactly one cycle. A start raised while `busy` is high is ignored. All results hold their values until the next accepted start.
- R10: `ok` is high exactly when `done` is high and neither error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (sampled only when idle) |
| ref_mhz | input | REF_W (10) | Reference frequency in MHz |
| tgt_mhz | input | TGT_W (11) | Wanted bit-clock frequency in MHz |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Run finished without error |
| err_bounds | output | 1 | Input divider span empty |
| err_range | output | 1 | Target above the top threshold |
| prediv | output | PD_W (8) | Chosen input divider |
| fbdiv | output | TGT_W (11) | Feedback divider |
| achieved_mhz | output | TGT_W (11) | Frequency reached |
| range_code | output | 6 | Frequency-range code |
| cfg_vco | output | 8 | VCO range byte |
| cfg_range | output | 8 | Range byte |
| cfg_indiv | output | 8 | Input divider byte |
| cfg_fb_lo | output | 8 | Feedback divider low byte |
| cfg_fb_hi | output | 8 | Feedback divider high byte |

## Verification
The hardest behaviour to reach from the ports is the search edge where the candidate span is empty or a single value. That happens for references from 5 to 14 MHz, where the result comes from the default divider or from one candidate and not from a real comparison. A ref of 4 or 0 must instead end in a bounds error with no division by zero. Random references seldom land there, so directed runs pin these references and the 1500/1501 MHz table edge. Constrained random pairs cover tie-breaking between equal remainders across wide spans, and one run raises start mid-search with different operands to show they are ignored.

// File: rtl/pll_solver_pkg.sv
// Package: shared state type and the constant frequency-range table.
// Assumes table indices 0..RANGE_N-1 in ascending threshold order.
package pll_solver_pkg;

    localparam int RANGE_N = 39;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BOUND,
        ST_SEARCH,
        ST_FINISH
    } solver_state_e;

    // Threshold in MHz for table row idx (ascending)
    function automatic int range_thr(input int idx);
        int t;
        case (idx)
            0: t = 90;    1: t = 100;   2: t = 110;   3: t = 130;
            4: t = 140;   5: t = 150;   6: t = 170;   7: t = 180;
            8: t = 200;   9: t = 220;   10: t = 240;  11: t = 250;
            12: t = 270;  13: t = 300;  14: t = 330;  15: t = 360;
            16: t = 400;  17: t = 450;  18: t = 500;  19: t = 550;
            20: t = 600;  21: t = 650;  22: t = 700;  23: t = 750;
            24: t = 800;  25: t = 850;  26: t = 900;  27: t = 950;
            28: t = 1000; 29: t = 1050; 30: t = 1100; 31: t = 1150;
            32: t = 1200; 33: t = 1250; 34: t = 1300; 35: t = 1350;
            36: t = 1400; 37: t = 1450; default: t = 1500;
        endcase
        return t;
    endfunction

    // Range code for table row idx
    function automatic logic [5:0] range_cd(input int idx);
        logic [5:0] c;
        case (idx)
            0: c = 6'h01;  1: c = 6'h10;  2: c = 6'h20;  3: c = 6'h01;
            4: c = 6'h11;  5: c = 6'h21;  6: c = 6'h02;  7: c = 6'h12;
            8: c = 6'h22;  9: c = 6'h03;  10: c = 6'h13; 11: c = 6'h23;
            12: c = 6'h04; 13: c = 6'h14; 14: c = 6'h05; 15: c = 6'h15;
            16: c = 6'h25; 17: c = 6'h06; 18: c = 6'h16; 19: c = 6'h07;
            20: c = 6'h17; 21: c = 6'h08; 22: c = 6'h18; 23: c = 6'h09;
            24: c = 6'h19; 25: c = 6'h29; 26: c = 6'h39; 27: c = 6'h0a;
            28: c = 6'h1a; 29: c = 6'h2a; 30: c = 6'h3a; 31: c = 6'h0b;
            32: c = 6'h1b; 33: c = 6'h2b; 34: c = 6'h3b; 35: c = 6'h0c;
            36: c = 6'h1c; 37: c = 6'h2c; default: c = 6'h3c;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pll_range_lut.sv
// Module: frequency-range lookup.
// Picks the lowest table row whose threshold is at or above the target.
// Assumes the table is ascending; flags a miss above the top threshold.
module pll_range_lut #(
    parameter int TGT_W = 11
) (
    input  logic [TGT_W-1:0] tgt,
    output logic [5:0]       code,
    output logic             miss
);
    import pll_solver_pkg::*;

    logic [RANGE_N-1:0] hit;

    // One comparator per table row
    for (genvar g = 0; g < RANGE_N; g++) begin : g_cmp
        assign hit[g] = (32'(tgt) <= 32'(range_thr(g)));
    end

    // Priority select of the lowest hitting row
    always_comb begin
        code = 6'h00;
        miss = 1'b1;
        for (int k = RANGE_N - 1; k >= 0; k--) begin
            if (hit[k]) begin
                code = range_cd(k);
                miss = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pll_div_search.sv
// Module: bounded input-divider search and feedback/achieved computation.
// Latches operands on start while idle, derives the candidate span, tests
// one candidate per clock, then computes the final results in one cycle.
// Assumes the caller never relies on results while busy is high.
module pll_div_search #(
    parameter int REF_W  = 10,
    parameter int TGT_W  = 11,
    parameter int PD_W   = 8,
    parameter int FB_CAP = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REF_W-1:0] ref_in,
    input  logic [TGT_W-1:0] tgt_in,
    output logic             busy,
    output logic             fin,
    output logic [TGT_W-1:0] tgt_work,
    output logic [PD_W-1:0]  prediv_o,
    output logic [TGT_W-1:0] fbdiv_o,
    output logic [TGT_W-1:0] ach_o,
    output logic [TGT_W-1:0] tgt_o,
    output logic             err_bounds_o
);
    import pll_solver_pkg::*;

    localparam int PROD_W = 32;

    solver_state_e    state;
    logic [REF_W-1:0] ref_q;
    logic [TGT_W-1:0] tgt_q;
    logic [REF_W-1:0] max_q;
    logic [REF_W-1:0] cand_q;
    logic [REF_W-1:0] best_rem;
    logic [PD_W-1:0]  best_pd;
    logic             err_q;

    logic [REF_W-1:0]  max_c, q40_c, min_c;
    logic [PROD_W-1:0] div_c, prod_c, rem_c, quo_c, pd_c, fb_c, ach_c;
    logic              take_c;

    // Candidate span bounds from the latched reference
    always_comb begin
        max_c = ref_q / REF_W'(5);
        q40_c = ref_q / REF_W'(40);
        min_c = (q40_c != '0) ? q40_c + REF_W'(1) : REF_W'(1);
    end

    // Candidate test and final divider arithmetic, divide-by-zero guarded
    always_comb begin
        div_c  = (ref_q == '0) ? PROD_W'(1) : PROD_W'(ref_q);
        prod_c = PROD_W'(tgt_q) * PROD_W'(cand_q);
        rem_c  = prod_c % div_c;
        quo_c  = prod_c / div_c;
        take_c = (rem_c < PROD_W'(best_rem)) && (quo_c < PROD_W'(FB_CAP));
        pd_c   = (best_pd == '0) ? PROD_W'(1) : PROD_W'(best_pd);
        fb_c   = (PROD_W'(tgt_q) * PROD_W'(best_pd)) / div_c;
        ach_c  = (PROD_W'(ref_q) * fb_c) / pd_c;
    end

    // Sequencer: latch, bound, search, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            ref_q        <= '0;
            tgt_q        <= '0;
            max_q        <= '0;
            cand_q       <= '0;
            best_rem     <= '0;
            best_pd      <= '0;
            err_q        <= 1'b0;
            prediv_o     <= '0;
            fbdiv_o      <= '0;
            ach_o        <= '0;
            tgt_o        <= '0;
            err_bounds_o <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        ref_q <= ref_in;
                        tgt_q <= tgt_in;
                        state <= ST_BOUND;
                    end
                end
                ST_BOUND: begin
                    max_q    <= max_c;
                    cand_q   <= min_c;
                    best_rem <= ref_q;
                    best_pd  <= PD_W'(1);
                    err_q    <= (max_c < min_c);
                    state    <= (max_c < min_c) ? ST_FINISH : ST_SEARCH;
                end
                ST_SEARCH: begin
                    if (cand_q < max_q) begin
                        if (take_c) begin
                            best_pd  <= PD_W'(cand_q);
                            best_rem <= REF_W'(rem_c);
                        end
                        cand_q <= cand_q + REF_W'(1);
                    end else begin
                        state <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    prediv_o     <= best_pd;
                    fbdiv_o      <= err_q ? '0 : TGT_W'(fb_c);
                    ach_o        <= err_q ? '0 : TGT_W'(ach_c);
                    tgt_o        <= tgt_q;
                    err_bounds_o <= err_q;
                    state        <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign fin      = (state == ST_FINISH);
    assign tgt_work = tgt_q;

endmodule

// File: rtl/pll_cfg_encode.sv
// Module: packs solver results into the five test-port configuration bytes.
// Purely combinational; assumes inputs are the held result registers.
module pll_cfg_encode #(
    parameter int PD_W  = 8,
    parameter int TGT_W = 11
) (
    input  logic [PD_W-1:0]  prediv,
    input  logic [TGT_W-1:0] fbdiv,
    input  logic [TGT_W-1:0] tgt,
    input  logic [5:0]       code,
    output logic [7:0]       b_vco,
    output logic [7:0]       b_range,
    output logic [7:0]       b_indiv,
    output logic [7:0]       b_fb_lo,
    output logic [7:0]       b_fb_hi
);
    logic [31:0] fbm1;
    logic [31:0] vsel;
    logic [31:0] pdm1;

    // Byte formation with 32-bit wrap before truncation
    always_comb begin
        fbm1    = 32'(fbdiv) - 32'd1;
        pdm1    = 32'(prediv) - 32'd1;
        vsel    = 32'(tgt) / 32'd200;
        b_vco   = 8'h80 | 8'(vsel << 3) | 8'h03;
        b_range = {1'b0, code, 1'b0};
        b_indiv = pdm1[7:0];
        b_fb_lo = {3'b000, fbm1[4:0]};
        b_fb_hi = 8'(fbm1 >> 5) | 8'h80;
    end

endmodule

// File: rtl/pll_solver.sv
// Top: PLL divider solver with range lookup and byte encoding.
// Start is taken only when idle; done pulses once; results hold afterwards.
// Assumes ref_mhz and tgt_mhz are whole MHz values.
module pll_solver #(
    parameter int REF_W   = 10,
    parameter int TGT_W   = 11,
    parameter int FB_CAP  = 512,
    localparam int PD_W   = $clog2((2 ** REF_W) / 5 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REF_W-1:0] ref_mhz,
    input  logic [TGT_W-1:0] tgt_mhz,
    output logic             busy,
    output logic             done,
    output logic             ok,
    output logic             err_bounds,
    output logic             err_range,
    output logic [PD_W-1:0]  prediv,
    output logic [TGT_W-1:0] fbdiv,
    output logic [TGT_W-1:0] achieved_mhz,
    output logic [5:0]       range_code,
    output logic [7:0]       cfg_vco,
    output logic [7:0]       cfg_range,
    output logic [7:0]       cfg_indiv,
    output logic [7:0]       cfg_fb_lo,
    output logic [7:0]       cfg_fb_hi
);
    logic             fin;
    logic [TGT_W-1:0] tgt_work;
    logic [TGT_W-1:0] tgt_res;
    logic [5:0]       lut_code;
    logic             lut_miss;
    logic             done_q;
    logic             err_r_q;
    logic [5:0]       code_q;

    pll_div_search #(
        .REF_W (REF_W),
        .TGT_W (TGT_W),
        .PD_W  (PD_W),
        .FB_CAP(FB_CAP)
    ) u_search (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .ref_in      (ref_mhz),
        .tgt_in      (tgt_mhz),
        .busy        (busy),
        .fin         (fin),
        .tgt_work    (tgt_work),
        .prediv_o    (prediv),
        .fbdiv_o     (fbdiv),
        .ach_o       (achieved_mhz),
        .tgt_o       (tgt_res),
        .err_bounds_o(err_bounds)
    );

    pll_range_lut #(.TGT_W(TGT_W)) u_lut (
        .tgt (tgt_work),
        .code(lut_code),
        .miss(lut_miss)
    );

    // Capture range result and done pulse on the finish cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            err_r_q <= 1'b0;
            code_q  <= '0;
        end else begin
            done_q <= fin;
            if (fin) begin
                err_r_q <= lut_miss;
                code_q  <= lut_code;
            end
        end
    end

    assign done       = done_q;
    assign err_range  = err_r_q;
    assign range_code = code_q;
    assign ok         = done_q & ~err_bounds & ~err_r_q;

    pll_cfg_encode #(.PD_W(PD_W), .TGT_W(TGT_W)) u_enc (
        .prediv (prediv),
        .fbdiv  (fbdiv),
        .tgt    (tgt_res),
        .code   (code_q),
        .b_vco  (cfg_vco),
        .b_range(cfg_range),
        .b_indiv(cfg_indiv),
        .b_fb_lo(cfg_fb_lo),
        .b_fb_hi(cfg_fb_hi)
    );

endmodule

// File: rtl/pll_solver_chk.sv
// Checker: temporal properties of the solver's handshake and results.
module pll_solver_chk #(
    parameter int PD_W  = 8,
    parameter int TGT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             ok,
    input logic             err_bounds,
    input logic             err_range,
    input logic [PD_W-1:0]  prediv,
    input logic [TGT_W-1:0] fbdiv
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R9
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                              // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(prediv) && $stable(fbdiv) && $stable(err_range))); // R9
    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (done && !err_bounds && !err_range));                  // R10
    AST_BOUND_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_bounds) |-> (prediv == PD_W'(1) && fbdiv == '0)); // R2
    AST_PREDIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (prediv != '0));                                       // R3
endmodule

bind pll_solver pll_solver_chk #(.PD_W(PD_W), .TGT_W(TGT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .ok        (ok),
    .err_bounds(err_bounds),
    .err_range (err_range),
    .prediv    (prediv),
    .fbdiv     (fbdiv)
);

// File: tb/pll_solver_bench.sv
module pll_solver_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  ref_mhz = '0;
    logic [10:0] tgt_mhz = '0;
    logic        busy, done, ok, err_bounds, err_range;
    logic [7:0]  prediv;
    logic [10:0] fbdiv, achieved_mhz;
    logic [5:0]  range_code;
    logic [7:0]  cfg_vco, cfg_range, cfg_indiv, cfg_fb_lo, cfg_fb_hi;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    localparam int THR [39] = '{90,100,110,130,140,150,170,180,200,220,240,250,
        270,300,330,360,400,450,500,550,600,650,700,750,800,850,900,950,1000,
        1050,1100,1150,1200,1250,1300,1350,1400,1450,1500};
    localparam int CDS [39] = '{'h01,'h10,'h20,'h01,'h11,'h21,'h02,'h12,'h22,
        'h03,'h13,'h23,'h04,'h14,'h05,'h15,'h25,'h06,'h16,'h07,'h17,'h08,'h18,
        'h09,'h19,'h29,'h39,'h0a,'h1a,'h2a,'h3a,'h0b,'h1b,'h2b,'h3b,'h0c,'h1c,
        'h2c,'h3c};

    always #2.5 clk = ~clk;

    pll_solver u_pll_solver (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_mhz(ref_mhz),
        .tgt_mhz(tgt_mhz), .busy(busy), .done(done), .ok(ok),
        .err_bounds(err_bounds), .err_range(err_range), .prediv(prediv),
        .fbdiv(fbdiv), .achieved_mhz(achieved_mhz), .range_code(range_code),
        .cfg_vco(cfg_vco), .cfg_range(cfg_range), .cfg_indiv(cfg_indiv),
        .cfg_fb_lo(cfg_fb_lo), .cfg_fb_hi(cfg_fb_hi)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (ref=%0d tgt=%0d)",
                     req, act, exp, ref_mhz, tgt_mhz);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Watchdog: counts as a failed check and still prints the summary
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, 190000);
            finish_run();
        end
    end

    // Reference model built from the requirements
    task automatic model(input int r, input int t,
                         output int pd, output int fb, output int ach,
                         output int code, output bit eb, output bit er);
        int mx, mn, rem;
        mx = r / 5;
        mn = ((r / 40) != 0) ? r / 40 + 1 : 1;
        eb = (mx < mn);
        pd = 1; fb = 0; ach = 0;
        if (!eb) begin
            rem = r;
            for (int i = mn; i < mx; i++) begin
                longint p = longint'(t) * i;
                if ((p % r) < rem && (p / r) < 512) begin
                    pd = i;
                    rem = int'(p % r);
                end
            end
            fb  = t * pd / r;
            ach = r * fb / pd;
        end
        er = (t > 1500);
        code = 0;
        if (!er) begin
            for (int k = 38; k >= 0; k--) if (t <= THR[k]) code = CDS[k];
        end
    endtask

    task automatic run_vec(input int r, input int t, input bit poke);
        int pd, fb, ach, code, wait_n;
        bit eb, er;
        bit [31:0] fbm1;
        int keep_pd, keep_fb;
        model(r, t, pd, fb, ach, code, eb, er);
        @(negedge clk);
        ref_mhz = 10'(r); tgt_mhz = 11'(t); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            chk("R9 busy during run", busy, 1);
            ref_mhz = 10'd999; tgt_mhz = 11'd777; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            ref_mhz = 10'(r); tgt_mhz = 11'(t);
        end
        wait_n = 0;
        while (!done && wait_n < 1000) begin
            @(negedge clk);
            wait_n++;
        end
        chk("R9 done reached", done, 1);
        chk("R2 err_bounds", err_bounds, eb);
        chk("R6 err_range", err_range, er);
        chk("R10 ok", ok, (!eb && !er));
        chk("R3 prediv", prediv, pd);
        chk("R4 fbdiv", fbdiv, fb);
        chk("R4 achieved", achieved_mhz, ach);
        chk("R5 range_code", range_code, code);
        chk("R5 cfg_range", cfg_range, (code << 1) & 255);
        chk("R7 cfg_indiv", cfg_indiv, (pd - 1) & 255);
        fbm1 = 32'(fb) - 32'd1;
        chk("R7 cfg_fb_lo", cfg_fb_lo, fbm1 & 31);
        chk("R7 cfg_fb_hi", cfg_fb_hi, ((fbm1 >> 5) | 32'h80) & 32'hFF);
        chk("R8 cfg_vco", cfg_vco, (128 | ((t / 200) << 3) | 3) & 255);
        keep_pd = prediv; keep_fb = fbdiv;
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
        chk("R9 prediv held", prediv, keep_pd);
        chk("R9 fbdiv held", fbdiv, keep_fb);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 ok after reset", ok, 0);
        chk("R1 prediv after reset", prediv, 0);
        chk("R1 fbdiv after reset", fbdiv, 0);
        chk("R1 range_code after reset", range_code, 0);

        // Directed corners
        run_vec(0, 500, 0);      // R2 zero reference
        run_vec(4, 500, 0);      // R2 span empty
        run_vec(5, 400, 0);      // R3 span min==max, default divider
        run_vec(10, 1000, 0);    // R3 single candidate
        run_vec(14, 777, 0);     // R3 small span
        run_vec(39, 600, 0);     // R2 lower bound 1
        run_vec(40, 600, 0);     // R2 lower bound 2
        run_vec(24, 1500, 0);    // R5 top threshold
        run_vec(24, 1501, 0);    // R6 just above
        run_vec(24, 2047, 0);    // R6 far above, R8 wrap
        run_vec(27, 90, 0);      // R5 first entry
        run_vec(27, 91, 0);      // R5 second entry
        run_vec(1000, 1200, 0);  // R3 wide span
        run_vec(100, 1000, 0);   // R3 ties between equal remainders
        run_vec(19, 1, 0);       // R7 fbdiv zero wrap
        run_vec(38, 900, 1);     // R9 start ignored while busy

        for (int n = 0; n < 250; n++) begin
            int r, t;
            r = int'($urandom_range(1000, 1));
            t = int'($urandom_range(1600, 1));
            run_vec(r, t, (n % 25) == 0);
        end
        finish_run();
    end
endmodule